// File: doc/BRIEF.md
# Bus Access Width Adapter

This block connects a processor-side bus, which issues 8-, 16- or 32-bit reads and writes at a byte address, to a memory port whose data width is fixed at elaboration time to 8, 16 or 32 bits. It places each byte on the memory lane that matches its address. When the access is narrower than the memory, it drives byte enables for the addressed lanes only. When the access is wider than the memory, it splits the access into several memory cycles at ascending addresses and collects the read bytes into one result. Byte order is little-endian on both sides.

The processor raises `req_i` for one clock with the access fields valid. The block latches the fields and runs the memory cycles. Each memory cycle holds `mem_req_o` until `mem_ack_i` is seen at a clock edge. When the last cycle has finished, `ready_o` goes high for exactly one clock. On a read, `rdata_o` carries the assembled data from that clock onward.

Top module: `bus_width_adapter`

## Requirements
- R1: `size_i` encodes the access width as 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. A request is taken only when `req_i` is high while the block is idle.
- R2: The address bits below the access size are ignored. The access always covers the naturally aligned bytes A..A+S-1, where S is the size in bytes and A is `addr_i` with its low log2(S) bits cleared.
- R3: An access uses max(1, S/MB) memory cycles, where MB is the memory width in bytes. The first cycle addresses A with its low log2(MB) bits cleared. Each further cycle addresses MB bytes higher.
- R4: During a memory cycle, `mem_req_o`, `mem_addr_o`, `mem_be_o` and `mem_wdata_o` stay constant until a clock edge at which `mem_ack_i` is high.
- R5: Lane l of the memory word (bits 8l+7:8l) carries byte address `mem_addr_o`+l. `mem_be_o[l]` is high exactly when that address lies inside the access. The number of enabled lanes is min(S, MB).
- R6: On writes, byte j of `wdata_i` (bits 8j+7:8j) is stored at address A+j. A lane that is not enabled still carries access byte (l mod S), so narrow write data appears replicated across the word.
- R7: On reads, the byte at address A+j appears at `rdata_o` bits 8j+7:8j. Bits above 8S-1 are zero.
- R8: `ready_o` is low from the start of an access until the final memory cycle is acknowledged, then high for exactly one clock. `rdata_o` changes only at the end of a read and keeps its value through later writes.
- R9: A `req_i` pulse that arrives while an access is in progress has no effect.
- R10: After reset, `mem_req_o`, `ready_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (sampled when idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width code |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data, little-endian |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read data |
| mem_req_o | output | 1 | Memory cycle active |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_addr_o | output | ADDR_W | Byte address of the memory word |
| mem_be_o | output | MEM_W/8 | Byte enables per lane |
| mem_wdata_o | output | MEM_W | Memory write data |
| mem_rdata_i | input | MEM_W | Memory read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Memory cycle complete |

## Verification
The bench targets three kinds of error. The first is a wrong byte order across a split 32-bit access: a design that swapped beats would return 0x01000302 where 0x03020100 is expected. The second is a misaligned address. A design that failed to clear the low bits would start at the wrong word, or enable the wrong lane for a byte at an odd address. The third covers sub-word accesses: the bench checks that write data is replicated on the disabled lanes and that the upper read bits are zero-filled. Memory acknowledges are delayed by a varying number of cycles, so a design that let its address drift, or counted beats without waiting for the acknowledge, would be caught. A stray request is injected mid-access; a design that accepted it would issue extra memory cycles after `ready_o`.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bwa_state_e;

  // width code -> bytes; codes 2 and 3 both mean a full 32-bit access
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [2:0]        acc_bytes_o,
  output logic              acc_we_o,
  output logic              start_o,
  output logic              last_o,
  output logic              ready_o
);

  localparam logic [ADDR_W-1:0] MB_MASK = ADDR_W'(MB - 1);
  localparam logic [ADDR_W-1:0] MB_STEP = ADDR_W'(MB);

  bwa_state_e        state_q;
  logic [1:0]        beat_q, last_beat_q;
  logic [2:0]        sb_in;
  logic [ADDR_W-1:0] addr_al;
  logic [1:0]        nb_in;

  always_comb begin
    sb_in   = size_bytes(size_i);
    addr_al = addr_i & ~ADDR_W'(sb_in - 3'd1);
    nb_in   = (int'(sb_in) > MB) ? 2'(int'(sb_in) / MB - 1) : 2'd0;
  end

  assign start_o   = (state_q == ST_IDLE) && req_i;
  assign mem_req_o = (state_q == ST_RUN);
  assign mem_we_o  = mem_req_o && acc_we_o;
  assign ready_o   = (state_q == ST_DONE);
  assign last_o    = (beat_q == last_beat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      last_beat_q <= '0;
      acc_addr_o  <= '0;
      acc_bytes_o <= 3'd1;
      acc_we_o    <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          state_q     <= ST_RUN;
          beat_q      <= '0;
          last_beat_q <= nb_in;
          acc_addr_o  <= addr_al;
          acc_bytes_o <= sb_in;
          acc_we_o    <= we_i;
          mem_addr_o  <= addr_al & ~MB_MASK;
        end
        ST_RUN: if (mem_ack_i) begin
          if (last_o) begin
            state_q <= ST_DONE;
          end else begin
            beat_q     <= beat_q + 2'd1;
            mem_addr_o <= mem_addr_o + MB_STEP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !last_o) |=> (mem_addr_o == $past(mem_addr_o) + MB_STEP)); // R3

  AST_CYCLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (!ready_o && !mem_req_o)); // R8

endmodule

// File: rtl/bwa_lane_map.sv
module bwa_lane_map #(
  parameter int ADDR_W = 16,
  parameter int MB     = 2
) (
  input  logic [ADDR_W-1:0]   mem_addr_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [2:0]          acc_bytes_i,
  input  logic [31:0]         wdata_i,
  output logic [MB-1:0]       lane_en_o,
  output logic [MB-1:0][1:0]  lane_idx_o,
  output logic [8*MB-1:0]     wdata_o
);

  logic [ADDR_W-1:0] sz_mask;
  assign sz_mask = ADDR_W'(acc_bytes_i - 3'd1);

  for (genvar l = 0; l < MB; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr      = mem_addr_i + ADDR_W'(l);
    // lane belongs to the access when its address falls in the aligned window
    assign lane_en_o[l]   = ((lane_addr & ~sz_mask) == acc_addr_i);
    // byte index within the access; wraps for narrow accesses -> replication
    assign lane_idx_o[l]  = lane_addr[1:0] & sz_mask[1:0];
    assign wdata_o[8*l +: 8] = wdata_i[{lane_idx_o[l], 3'b000} +: 8];
  end

endmodule

// File: rtl/bwa_rd_pack.sv
module bwa_rd_pack #(
  parameter int MB = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cap_i,
  input  logic               last_i,
  input  logic               we_i,
  input  logic [MB-1:0]      lane_en_i,
  input  logic [MB-1:0][1:0] lane_idx_i,
  input  logic [8*MB-1:0]    mem_rdata_i,
  output logic [31:0]        rdata_o
);

  logic [31:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    for (int l = 0; l < MB; l++) begin
      if (lane_en_i[l]) acc_d[{lane_idx_i[l], 3'b000} +: 8] = mem_rdata_i[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (start_i)    acc_q <= '0;
      else if (cap_i) acc_q <= acc_d;
      if (cap_i && last_i && !we_i) rdata_o <= acc_d;
    end
  end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int MEM_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              ready_o,
  output logic [31:0]       rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [MEM_W/8-1:0] mem_be_o,
  output logic [MEM_W-1:0]  mem_wdata_o,
  input  logic [MEM_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i
);

  localparam int MB = MEM_W / 8;

  logic              start, last, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [2:0]        acc_bytes;
  logic [31:0]       wdata_q;
  logic [MB-1:0]     lane_en;
  logic [MB-1:0][1:0] lane_idx;

  bwa_ctrl #(.ADDR_W(ADDR_W), .MB(MB)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .size_i      (size_i),
    .addr_i      (addr_i),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .acc_addr_o  (acc_addr),
    .acc_bytes_o (acc_bytes),
    .acc_we_o    (acc_we),
    .start_o     (start),
    .last_o      (last),
    .ready_o     (ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wdata_q <= '0;
    else if (start) wdata_q <= wdata_i;
  end

  bwa_lane_map #(.ADDR_W(ADDR_W), .MB(MB)) u_lane_map (
    .mem_addr_i  (mem_addr_o),
    .acc_addr_i  (acc_addr),
    .acc_bytes_i (acc_bytes),
    .wdata_i     (wdata_q),
    .lane_en_o   (lane_en),
    .lane_idx_o  (lane_idx),
    .wdata_o     (mem_wdata_o)
  );

  assign mem_be_o = lane_en & {MB{mem_req_o}};

  bwa_rd_pack #(.MB(MB)) u_rd_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cap_i       (mem_req_o && mem_ack_i),
    .last_i      (last),
    .we_i        (acc_we),
    .lane_en_i   (lane_en),
    .lane_idx_i  (lane_idx),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o)
  );

  AST_BE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == ((int'(acc_bytes) >= MB) ? MB : int'(acc_bytes)))); // R5

  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !acc_we && acc_bytes == 3'd1) |-> (rdata_o[31:8] == 24'd0)); // R7

endmodule

// File: tb/bus_width_adapter_bench.sv
module bus_width_adapter_bench;
  localparam int MEM_W  = 16;
  localparam int MB     = MEM_W / 8;
  localparam int ADDR_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              req_i, we_i;
  logic [1:0]        size_i;
  logic [ADDR_W-1:0] addr_i;
  logic [31:0]       wdata_i;
  logic              ready_o;
  logic [31:0]       rdata_o;
  logic              mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [MB-1:0]     mem_be_o;
  logic [MEM_W-1:0]  mem_wdata_o;
  logic [MEM_W-1:0]  mem_rdata_i;
  logic              mem_ack_i;

  bus_width_adapter #(.MEM_W(MEM_W), .ADDR_W(ADDR_W)) u_bus_width_adapter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i)
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic             we;
    logic [31:0]      rdata;
    int               beats;
    logic [15:0]      faddr;
    logic [MB-1:0]    fbe;
    logic [MEM_W-1:0] fwd;
    string            tag;
  } item_t;

  item_t       sb_q[$];
  logic [7:0]  mem_arr [0:255];
  logic [7:0]  ref_mem [0:255];
  logic [31:0] last_rd = '0;

  // memory model state
  int          wait_cycles = 0;
  int          waited = 0;
  int          beat_cnt = 0;
  bit          in_beat = 0;
  logic [15:0] beat_addr, last_addr, first_addr;
  logic [MB-1:0]    beat_be, first_be;
  logic [MEM_W-1:0] beat_wd, first_wd;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // memory responder
  initial begin
    mem_ack_i   = 1'b0;
    mem_rdata_i = '1;
    for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i) ^ 8'h5A;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i   = 1'b0;
        mem_rdata_i = {MB{8'hEE}};
      end else if (rst_ni && mem_req_o) begin
        if (!in_beat) begin
          in_beat = 1; waited = 0;
          beat_addr = mem_addr_o; beat_be = mem_be_o; beat_wd = mem_wdata_o;
          if (beat_cnt == 0) begin
            first_addr = mem_addr_o; first_be = mem_be_o; first_wd = mem_wdata_o;
          end else begin
            check("R3 beat address step", 32'(mem_addr_o), 32'(last_addr + 16'(MB)));
          end
        end else begin
          check("R4 held address", 32'(mem_addr_o), 32'(beat_addr));
          check("R4 held enables/data", 32'({mem_be_o, mem_wdata_o}), 32'({beat_be, beat_wd}));
        end
        if (waited < wait_cycles) begin
          waited++;
        end else begin
          for (int l = 0; l < MB; l++) begin
            if (mem_we_o && mem_be_o[l]) mem_arr[8'(beat_addr + 16'(l))] = mem_wdata_o[8*l +: 8];
            mem_rdata_i[8*l +: 8] = mem_arr[8'(beat_addr + 16'(l))];
          end
          mem_ack_i = 1'b1;
          beat_cnt++;
          last_addr = beat_addr;
          in_beat = 0;
        end
      end
    end
  end

  // monitor: pops expected items on each completion
  initial begin
    bit prev_rdy = 0;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (ready_o) begin
          check("R8 ready one clock", 32'(prev_rdy), 32'd0);
          if (sb_q.size() == 0) begin
            check("R9 unexpected completion", 32'd1, 32'd0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check({"R3 beat count ", it.tag}, 32'(beat_cnt), 32'(it.beats));
            check({"R3 first address ", it.tag}, 32'(first_addr), 32'(it.faddr));
            check({"R5 byte enables ", it.tag}, 32'(first_be), 32'(it.fbe));
            if (it.we) check({"R6 write lanes ", it.tag}, 32'(first_wd), 32'(it.fwd));
            check({it.we ? "R8 rdata kept " : "R7 read data ", it.tag}, rdata_o, it.rdata);
          end
          beat_cnt = 0;
        end
        prev_rdy = ready_o;
      end
    end
  end

  task automatic access(logic we, logic [1:0] sz, logic [15:0] addr, logic [31:0] wd,
                        string tag, bit inject);
    item_t       it;
    int          sb;
    logic [15:0] a, fa;
    logic [31:0] r;
    sb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    a  = addr & ~16'(sb - 1);
    fa = a & ~16'(MB - 1);
    it.we = we; it.tag = tag; it.faddr = fa;
    it.beats = (sb > MB) ? sb / MB : 1;
    for (int l = 0; l < MB; l++) begin
      it.fbe[l] = (int'(fa) + l >= int'(a)) && (int'(fa) + l < int'(a) + sb);
      it.fwd[8*l +: 8] = (sb >= MB) ? wd[8*l +: 8] : wd[8*(l % sb) +: 8];
    end
    if (we) begin
      for (int j = 0; j < sb; j++) ref_mem[8'(a + 16'(j))] = wd[8*j +: 8];
      it.rdata = last_rd;
    end else begin
      r = '0;
      for (int j = 0; j < sb; j++) r[8*j +: 8] = ref_mem[8'(a + 16'(j))];
      it.rdata = r;
      last_rd = r;
    end
    sb_q.push_back(it);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = addr; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0; wdata_i = 32'hDEAD_BEEF; addr_i = 16'hFFFF;
    if (inject) begin
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b1; size_i = 2'd0; addr_i = 16'h00F0; wdata_i = 32'hFFFF_FFFF;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; size_i = '0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    check("R10 reset mem_req", 32'(mem_req_o), 32'd0);
    check("R10 reset ready", 32'(ready_o), 32'd0);
    check("R10 reset rdata", rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wait_cycles = 0;
    access(1'b1, 2'd2, 16'h0010, 32'h0302_0100, "R6 split word write", 1'b0);
    access(1'b0, 2'd2, 16'h0010, 32'h0, "R7 split word read", 1'b0);
    check("R7 little-endian word", rdata_o, 32'h0302_0100);
    access(1'b0, 2'd1, 16'h0012, 32'h0, "R7 upper half", 1'b0);
    check("R7 half 0x0302", rdata_o, 32'h0000_0302);
    wait_cycles = 1;
    access(1'b0, 2'd1, 16'h0011, 32'h0, "R2 misaligned half", 1'b0);
    check("R2 aligned half 0x0100", rdata_o, 32'h0000_0100);
    access(1'b1, 2'd0, 16'h0021, 32'h0000_00AB, "R5 odd byte write", 1'b0);
    access(1'b0, 2'd0, 16'h0021, 32'h0, "R7 odd byte read", 1'b0);
    access(1'b0, 2'd2, 16'h0023, 32'h0, "R2 misaligned word", 1'b0);
    wait_cycles = 2;
    access(1'b0, 2'd3, 16'h0012, 32'h0, "R1 code 3 word", 1'b0);
    access(1'b1, 2'd1, 16'h0031, 32'h5555_C3D4, "R6 half write", 1'b0);
    access(1'b0, 2'd2, 16'h0030, 32'h0, "R7 word over half", 1'b0);
    access(1'b1, 2'd0, 16'h0040, 32'h0000_0077, "R8 byte write keeps rdata", 1'b0);
    access(1'b0, 2'd2, 16'h0010, 32'h0, "R9 read with stray req", 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R9 no extra memory cycle", 32'(mem_req_o), 32'd0);
    end
    access(1'b0, 2'd0, 16'h00F0, 32'h0, "R9 stray write absent", 1'b0);
    check("R9 untouched byte", rdata_o, 32'(8'hF0 ^ 8'h5A));
    wait_cycles = 0;
    access(1'b0, 2'd0, 16'h0040, 32'h0, "R7 byte zero-extend", 1'b0);
    check("R7 zero upper bits", rdata_o, 32'h0000_0077);

    repeat (4) @(negedge clk_i);
    check("R8 all items drained", 32'(sb_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule